// File: doc/BRIEF.md
# Multi-Channel Hit Time Stamper

This block stamps the arrival time of asynchronous hit pulses on a set of independent channels. A shared free-running coarse clock counter, kept in reflected binary Gray code, runs in the sampling clock domain. Its number of active bits can be set, so the counter wraps sooner when a shorter timestamp is enough. Each channel brings its hit line into the clock domain through a two-flop synchronizer and detects the rising edge. On that edge it stores the current Gray count together with a 5-bit fine-time code from an external interpolator. It then offers the captured word to a downstream buffer through a valid/ready handshake.

Each channel runs its own small controller: idle, capture, waiting for acceptance, and a fixed dead time. Hits that arrive while a word is pending or during the dead time are dropped, which caps the sustained rate per channel. A global controller holds the block in a clear state. While clear is requested, the counter sits at zero, every channel returns to idle and any pending word is thrown away. The counter width can only be changed while the block is in this clear state.

Top module: `hs_hit_stamp`

## Requirements
- R1: While `rst` is high and on the cycle after it, `clr_active` is 1, every `out_valid` bit is 0 and `time_gray` is 0. The active counter width after reset is `CNT_MAX_W`.
- R2: `clear_req` high at a clock edge makes `clr_active` 1 from the next cycle. `clear_req` low makes it 0 from the next cycle. One cycle after `clr_active` rises, every `out_valid` is 0 and any pending word is discarded. During clear, `time_gray` is 0 from the second cycle on.
- R3: While running, `time_gray` equals the reflected binary Gray code (g = b XOR (b >> 1)) of the number of cycles elapsed since the first running cycle, which shows 0. Successive running values differ in exactly one bit.
- R4: A loaded width W in 1..CNT_MAX_W makes the count wrap modulo 2^W, and bits W and above of `time_gray` stay 0. A loaded value of 0 or above `CNT_MAX_W` selects the full `CNT_MAX_W` bits.
- R5: `width_cfg` is taken only at an edge where `width_load` is 1 and `clr_active` is 1. A load attempted while running has no effect on the count.
- R6: If a channel's hit line goes high in a cycle where the count is n, then `out_coarse` for that channel holds the Gray code of n+2 (wrapped to the active width). `out_fine` holds the channel's `fine_code` field as it stood at that capture. `out_valid` rises on the fourth rising edge after the hit went high.
- R7: While `out_valid` is 1 and `out_ready` is 0, the valid bit, coarse word and fine code stay unchanged. An edge with both high accepts the word, and `out_valid` is 0 on the next cycle.
- R8: A hit line held high for many cycles produces exactly one captured word.
- R9: A rising hit edge detected while a word is pending, or within `DEAD_CYC` cycles after the accepting edge, is dropped and never produces a word. A hit after the dead time is captured normally.
- R10: Channels are independent. Simultaneous hits on two channels give two words on the same cycle with equal coarse values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_req | input | 1 | Level request to hold the block in clear |
| width_load | input | 1 | Strobe to load `width_cfg` (clear state only) |
| width_cfg | input | CFG_W | Requested active counter width |
| hit_in | input | NUM_CH | Asynchronous hit lines, one per channel |
| fine_code | input | NUM_CH*FINE_W | Fine-time code per channel, channel c at bits c*FINE_W upward |
| out_ready | input | NUM_CH | Downstream buffer ready, per channel |
| out_valid | output | NUM_CH | Captured word available, per channel |
| out_coarse | output | NUM_CH*CNT_MAX_W | Captured Gray count per channel, channel c at bits c*CNT_MAX_W upward |
| out_fine | output | NUM_CH*FINE_W | Captured fine code per channel |
| clr_active | output | 1 | Global controller is in its clear state |
| time_gray | output | CNT_MAX_W | Current Gray-coded coarse count |

## Verification
The embedded assertions check several properties on every cycle. They check the one-bit Gray step, zero upper bits beyond the active width, and the counter held at zero under clear. They check that the width changes only after a cycle in clear, that the clear and run transitions follow the request, and that a pending word holds steady until accepted. They also check the minimum spacing of dead time between an acceptance and the next valid. Only the bench's scenarios can show the exact count stored for a hit at a known time and the fourth-edge valid latency. The same holds for a held hit yielding a single word, drops during waiting and dead time, independence of channels, and the effect of loaded widths on the wrap point.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    CH_IDLE    = 2'd0,
    CH_CAPTURE = 2'd1,
    CH_DEAD    = 2'd2,
    CH_WAIT    = 2'd3
  } ch_state_t;

  typedef enum logic {
    GL_CLEAR = 1'b0,
    GL_RUN   = 1'b1
  } gl_state_t;

endpackage

// File: rtl/hs_global_ctl.sv
module hs_global_ctl (
  input  logic clk,
  input  logic rst,
  input  logic clear_req,
  input  logic width_load,
  output logic run_o,
  output logic clr_o,
  output logic cfg_we_o
);
  import hs_pkg::*;

  gl_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GL_CLEAR;
    end else begin
      case (state_q)
        GL_CLEAR: if (!clear_req) state_q <= GL_RUN;
        GL_RUN:   if (clear_req)  state_q <= GL_CLEAR;
        default:  state_q <= GL_CLEAR;
      endcase
    end
  end

  assign run_o    = (state_q == GL_RUN);
  assign clr_o    = (state_q == GL_CLEAR);
  assign cfg_we_o = width_load && (state_q == GL_CLEAR);

  // R2
  enter_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> clr_o);

  // R2
  leave_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !clear_req |=> run_o);

endmodule

// File: rtl/hs_gray_timer.sv
module hs_gray_timer #(
  parameter int CNT_MAX_W = 48,
  parameter int CFG_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_val,
  output logic [CNT_MAX_W-1:0] gray_o
);

  logic [CFG_W-1:0]     width_q;
  logic [CNT_MAX_W-1:0] mask;
  logic [CNT_MAX_W-1:0] bin_q;
  logic [CNT_MAX_W-1:0] bin_inc;
  logic [CNT_MAX_W-1:0] gray_q;
  logic                 cfg_full;

  assign cfg_full = (int'(cfg_val) == 0) || (int'(cfg_val) > CNT_MAX_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= CFG_W'(CNT_MAX_W);
    end else if (cfg_we) begin
      width_q <= cfg_full ? CFG_W'(CNT_MAX_W) : cfg_val;
    end
  end

  always_comb begin
    for (int i = 0; i < CNT_MAX_W; i++) begin
      mask[i] = (i < int'(width_q));
    end
  end

  assign bin_inc = (bin_q + CNT_MAX_W'(1)) & mask;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_inc;
      gray_q <= bin_inc ^ (bin_inc >> 1);
    end
  end

  assign gray_o = gray_q;

  // R3
  gray_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> ($countones(gray_q ^ $past(gray_q)) == 1));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (gray_q & ~mask) == '0);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (gray_q == '0));

  // R5
  width_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(width_q) |-> $past(!run));

endmodule

// File: rtl/hs_channel.sv
module hs_channel #(
  parameter int CNT_MAX_W = 48,
  parameter int FINE_W    = 5,
  parameter int DEAD_CYC  = 156
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 hit_i,
  input  logic [FINE_W-1:0]    fine_i,
  input  logic [CNT_MAX_W-1:0] stamp_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [CNT_MAX_W-1:0] coarse_o,
  output logic [FINE_W-1:0]    fine_o
);
  import hs_pkg::*;

  localparam int DCW    = $clog2(DEAD_CYC + 1);
  localparam int GW     = $clog2(DEAD_CYC + 8);
  localparam int GAPSAT = DEAD_CYC + 4;

  logic                 sy1_q, sy2_q, sy3_q;
  logic                 rise;
  ch_state_t            state_q;
  logic [DCW-1:0]       dead_q;
  logic                 valid_q;
  logic [CNT_MAX_W-1:0] coarse_q;
  logic [FINE_W-1:0]    fine_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1_q <= 1'b0;
      sy2_q <= 1'b0;
      sy3_q <= 1'b0;
    end else begin
      sy1_q <= hit_i;
      sy2_q <= sy1_q;
      sy3_q <= sy2_q;
    end
  end

  assign rise = sy2_q && !sy3_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q  <= CH_IDLE;
      dead_q   <= '0;
      valid_q  <= 1'b0;
      coarse_q <= '0;
      fine_q   <= '0;
    end else begin
      case (state_q)
        CH_IDLE: begin
          if (rise) begin
            coarse_q <= stamp_i;
            fine_q   <= fine_i;
            state_q  <= CH_CAPTURE;
          end
        end
        CH_CAPTURE: begin
          valid_q <= 1'b1;
          state_q <= CH_WAIT;
        end
        CH_WAIT: begin
          if (ready_i) begin
            valid_q <= 1'b0;
            dead_q  <= '0;
            state_q <= CH_DEAD;
          end
        end
        CH_DEAD: begin
          if (dead_q == DCW'(DEAD_CYC - 1)) begin
            state_q <= CH_IDLE;
          end else begin
            dead_q <= dead_q + DCW'(1);
          end
        end
        default: state_q <= CH_IDLE;
      endcase
    end
  end

  assign valid_o  = valid_q;
  assign coarse_o = coarse_q;
  assign fine_o   = fine_q;

  // Cycles since the last accepted word, saturating; used only by checks.
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      gap_q <= GW'(GAPSAT);
    end else if (valid_q && ready_i) begin
      gap_q <= '0;
    end else if (gap_q != GW'(GAPSAT)) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  // R9
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst || clr)
    $rose(valid_o) |-> (gap_q >= GW'(DEAD_CYC)));

  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (valid_o && !ready_i) |=> (valid_o && $stable(coarse_o) && $stable(fine_o)));

  // R7
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i) |=> !valid_o);

  // R2
  clear_flush_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid_o);

endmodule

// File: rtl/hs_hit_stamp.sv
module hs_hit_stamp #(
  parameter int NUM_CH    = 16,
  parameter int CNT_MAX_W = 48,
  parameter int FINE_W    = 5,
  parameter int CFG_W     = 6,
  parameter int DEAD_CYC  = 156
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear_req,
  input  logic                        width_load,
  input  logic [CFG_W-1:0]            width_cfg,
  input  logic [NUM_CH-1:0]           hit_in,
  input  logic [NUM_CH*FINE_W-1:0]    fine_code,
  input  logic [NUM_CH-1:0]           out_ready,
  output logic [NUM_CH-1:0]           out_valid,
  output logic [NUM_CH*CNT_MAX_W-1:0] out_coarse,
  output logic [NUM_CH*FINE_W-1:0]    out_fine,
  output logic                        clr_active,
  output logic [CNT_MAX_W-1:0]        time_gray
);

  logic run;
  logic clr;
  logic cfg_we;
  logic [CNT_MAX_W-1:0] gray;

  hs_global_ctl u_glb (
    .clk        (clk),
    .rst        (rst),
    .clear_req  (clear_req),
    .width_load (width_load),
    .run_o      (run),
    .clr_o      (clr),
    .cfg_we_o   (cfg_we)
  );

  hs_gray_timer #(
    .CNT_MAX_W (CNT_MAX_W),
    .CFG_W     (CFG_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .cfg_we  (cfg_we),
    .cfg_val (width_cfg),
    .gray_o  (gray)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hs_channel #(
      .CNT_MAX_W (CNT_MAX_W),
      .FINE_W    (FINE_W),
      .DEAD_CYC  (DEAD_CYC)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .hit_i    (hit_in[c]),
      .fine_i   (fine_code[c*FINE_W +: FINE_W]),
      .stamp_i  (gray),
      .ready_i  (out_ready[c]),
      .valid_o  (out_valid[c]),
      .coarse_o (out_coarse[c*CNT_MAX_W +: CNT_MAX_W]),
      .fine_o   (out_fine[c*FINE_W +: FINE_W])
    );
  end

  assign clr_active = clr;
  assign time_gray  = gray;

endmodule

// File: tb/tb_hs_hit_stamp.sv
`timescale 1ns/100ps
module tb_hs_hit_stamp;

  localparam int NCH = 4;
  localparam int CW  = 48;
  localparam int FW  = 5;
  localparam int GW  = 6;
  localparam int DC  = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clear_req = 1'b1;
  logic              width_load = 1'b0;
  logic [GW-1:0]     width_cfg = '0;
  logic [NCH-1:0]    hit_in = '0;
  logic [NCH*FW-1:0] fine_code = '0;
  logic [NCH-1:0]    out_ready = '0;
  logic [NCH-1:0]    out_valid;
  logic [NCH*CW-1:0] out_coarse;
  logic [NCH*FW-1:0] out_fine;
  logic              clr_active;
  logic [CW-1:0]     time_gray;

  hs_hit_stamp #(.NUM_CH(NCH), .CNT_MAX_W(CW), .FINE_W(FW), .CFG_W(GW), .DEAD_CYC(DC)) dut (
    .clk(clk), .rst(rst), .clear_req(clear_req), .width_load(width_load),
    .width_cfg(width_cfg), .hit_in(hit_in), .fine_code(fine_code),
    .out_ready(out_ready), .out_valid(out_valid), .out_coarse(out_coarse),
    .out_fine(out_fine), .clr_active(clr_active), .time_gray(time_gray)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [CW-1:0] mask = '1;

  // stimulus table: {channel, fine code, idle cycles before the hit}
  localparam logic [14:0] VEC [6] = '{
    {2'd0, 5'd3,  8'd5},
    {2'd1, 5'd17, 8'd9},
    {2'd2, 5'd31, 8'd1},
    {2'd3, 5'd0,  8'd23},
    {2'd0, 5'd12, 8'd40},
    {2'd2, 5'd21, 8'd3}
  };

  function automatic logic [CW-1:0] b2g(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // count monitor: reference count of running cycles (R3, R4)
  logic [CW-1:0] ref_cnt = '0;
  bit was_clr = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (clr_active) begin
        was_clr = 1'b1;
        ref_cnt = '0;
      end else begin
        if (was_clr) ref_cnt = '0;
        else ref_cnt = (ref_cnt + 1'b1) & mask;
        was_clr = 1'b0;
        chk(time_gray == b2g(ref_cnt), "R3 count", 64'(time_gray), 64'(b2g(ref_cnt)));
      end
    end
  end

  task automatic hit_on(input int ch, input logic [FW-1:0] f, output logic [CW-1:0] expc);
    logic [CW-1:0] e0;
    fine_code[ch*FW +: FW] = f;
    hit_in[ch] = 1'b1;
    e0 = g2b(time_gray);
    expc = b2g((e0 + 2) & mask);
  endtask

  task automatic fire(input int ch, input logic [FW-1:0] f, output logic [CW-1:0] expc);
    hit_on(ch, f, expc);
    tick(); tick();
    hit_in[ch] = 1'b0;
  endtask

  task automatic wait_valid(input int ch, input string tag);
    int k = 0;
    while (!out_valid[ch] && k < 20) begin tick(); k++; end
    chk(out_valid[ch] == 1'b1, tag, 64'(out_valid[ch]), 64'd1);
  endtask

  task automatic accept(input int ch);
    out_ready[ch] = 1'b1;
    tick();
    out_ready[ch] = 1'b0;
    chk(out_valid[ch] == 1'b0, "R7 drop after accept", 64'(out_valid[ch]), 64'd0);
  endtask

  task automatic quiet(input int ch, input int cyc, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      tick();
      if (out_valid[ch]) seen = 1'b1;
    end
    chk(!seen, tag, 64'(seen), 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] ec, ec2;
    logic [CW-1:0] gmax;
    bit upper_bad;
    repeat (4) tick();
    // R1: reset state
    chk(clr_active == 1'b1, "R1 clr_active", 64'(clr_active), 64'd1);
    chk(out_valid == '0, "R1 out_valid", 64'(out_valid), 64'd0);
    chk(time_gray == '0, "R1 time_gray", 64'(time_gray), 64'd0);
    rst = 1'b0;
    tick();
    chk(clr_active == 1'b1 && time_gray == '0, "R1 after reset", 64'(time_gray), 64'd0);
    tick();
    clear_req = 1'b0;
    tick();
    // R2: leave clear on the next cycle
    chk(clr_active == 1'b0, "R2 run entry", 64'(clr_active), 64'd0);
    repeat (3) tick();

    // table walk: R6 capture value, R7 hold and accept
    foreach (VEC[v]) begin
      int ch;
      logic [FW-1:0] f;
      ch = int'(VEC[v][14:13]);
      f  = VEC[v][12:8];
      repeat (int'(VEC[v][7:0])) tick();
      fire(ch, f, ec);
      wait_valid(ch, "R6 valid");
      chk(out_coarse[ch*CW +: CW] == ec, "R6 coarse", 64'(out_coarse[ch*CW +: CW]), 64'(ec));
      chk(out_fine[ch*FW +: FW] == f, "R6 fine", 64'(out_fine[ch*FW +: FW]), 64'(f));
      repeat (3) tick();
      chk(out_valid[ch] && out_coarse[ch*CW +: CW] == ec && out_fine[ch*FW +: FW] == f,
          "R7 hold while not ready", 64'(out_coarse[ch*CW +: CW]), 64'(ec));
      accept(ch);
      repeat (DC + 4) tick();
    end

    // R6 exact latency: valid on the fourth edge after the hit
    hit_on(1, 5'd7, ec);
    tick(); tick();
    hit_in[1] = 1'b0;
    tick();
    chk(out_valid[1] == 1'b0, "R6 latency early", 64'(out_valid[1]), 64'd0);
    tick();
    chk(out_valid[1] == 1'b1, "R6 latency edge4", 64'(out_valid[1]), 64'd1);
    chk(out_coarse[1*CW +: CW] == ec, "R6 latency coarse", 64'(out_coarse[1*CW +: CW]), 64'(ec));
    accept(1);
    repeat (DC + 4) tick();

    // R8: held hit gives one word
    hit_on(1, 5'd9, ec);
    wait_valid(1, "R8 first word");
    accept(1);
    quiet(1, 3 * DC, "R8 single word for held hit");
    hit_in[1] = 1'b0;
    repeat (4) tick();

    // R9: hit during dead time dropped
    fire(2, 5'd4, ec);
    wait_valid(2, "R9 setup");
    accept(2);
    fire(2, 5'd5, ec);
    quiet(2, 3 * DC, "R9 dropped in dead time");
    fire(2, 5'd6, ec);
    wait_valid(2, "R9 capture after dead time");
    chk(out_fine[2*FW +: FW] == 5'd6, "R9 fine after dead", 64'(out_fine[2*FW +: FW]), 64'd6);
    accept(2);
    repeat (DC + 4) tick();

    // R9: hit while word pending dropped
    fire(3, 5'd1, ec);
    wait_valid(3, "R9 pending setup");
    fire(3, 5'd9, ec2);
    repeat (4) tick();
    chk(out_fine[3*FW +: FW] == 5'd1, "R9 pending word kept", 64'(out_fine[3*FW +: FW]), 64'd1);
    accept(3);
    quiet(3, 3 * DC, "R9 dropped while pending");

    // R10: two channels at once
    fine_code[0*FW +: FW] = 5'd2;
    hit_on(1, 5'd8, ec);
    hit_in[0] = 1'b1;
    tick(); tick();
    hit_in[1:0] = 2'b00;
    wait_valid(0, "R10 ch0 valid");
    chk(out_valid[1] == 1'b1, "R10 ch1 valid", 64'(out_valid[1]), 64'd1);
    chk(out_coarse[0 +: CW] == out_coarse[CW +: CW] && out_coarse[0 +: CW] == ec,
        "R10 equal coarse", 64'(out_coarse[0 +: CW]), 64'(ec));
    accept(0);
    accept(1);
    repeat (DC + 4) tick();

    // R2: clear discards a pending word
    fire(0, 5'd11, ec);
    wait_valid(0, "R2 pending setup");
    clear_req = 1'b1;
    tick();
    chk(clr_active == 1'b1, "R2 clear entry", 64'(clr_active), 64'd1);
    tick();
    chk(out_valid == '0 && time_gray == '0, "R2 flush", 64'(out_valid), 64'd0);
    clear_req = 1'b0;
    quiet(0, 20, "R2 discarded word stays gone");

    // R4: width 4 wraps at 16
    clear_req = 1'b1;
    tick(); tick();
    width_cfg = 6'd4;
    width_load = 1'b1;
    tick();
    width_load = 1'b0;
    mask = 48'hF;
    clear_req = 1'b0;
    gmax = '0;
    upper_bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (time_gray > gmax) gmax = time_gray;
      if (time_gray[CW-1:4] != '0) upper_bad = 1'b1;
    end
    chk(!upper_bad && gmax == 48'hF, "R4 width 4 range", 64'(gmax), 64'hF);
    fire(1, 5'd13, ec);
    wait_valid(1, "R4 capture at width 4");
    chk(out_coarse[CW +: CW] == ec, "R4 wrapped coarse", 64'(out_coarse[CW +: CW]), 64'(ec));
    accept(1);

    // R5: load while running ignored
    width_cfg = 6'd8;
    width_load = 1'b1;
    tick();
    width_load = 1'b0;
    upper_bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (time_gray[CW-1:4] != '0) upper_bad = 1'b1;
    end
    chk(!upper_bad, "R5 running load ignored", 64'(upper_bad), 64'd0);

    // R4: value 0 selects full width
    clear_req = 1'b1;
    tick(); tick();
    width_cfg = 6'd0;
    width_load = 1'b1;
    tick();
    width_load = 1'b0;
    mask = '1;
    clear_req = 1'b0;
    repeat (40) tick();
    chk(g2b(time_gray) > 48'd15, "R4 zero selects full width", 64'(g2b(time_gray)), 64'd39);

    // R4: value above maximum selects full width
    clear_req = 1'b1;
    tick(); tick();
    width_cfg = 6'd50;
    width_load = 1'b1;
    tick();
    width_load = 1'b0;
    clear_req = 1'b0;
    repeat (300) tick();
    chk(g2b(time_gray) > 48'd255, "R4 oversize selects full width", 64'(g2b(time_gray)), 64'd299);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule